// File: doc/BRIEF.md
# Quota-Weighted Warp Instruction Dispatcher

This block sits between a warp scheduler and the execution clusters of a small GPU. Its job is to hand out ready warp instructions, each one standing for 32 lanes of work, so that every cluster receives a programmed number of instructions per distribution round. Eight clusters are served. Indices 0 to 5 are general arithmetic clusters and indices 6 and 7 are special-function clusters. An instruction of either kind may only go to a cluster of its own group.

Before a kernel starts, the host fills one 16-bit quota per cluster while the kernel-active input is low. During the kernel each instruction is sent to the lowest-index cluster that is available, belongs to the right group, and is still below its quota. When every cluster of a group has used up its quota, that group's counters start a fresh round on the next instruction of that kind. A quota of zero takes a cluster out of service. Grant and handshake are combinational in the cycle of the request. A counter readback port exposes each cluster's issued count.

Top module: `quota_dispatch`

## Requirements
- R1: While reset is asserted and just after it, every issue counter reads zero through the readback port, instReady is low and grant is all zeros.
- R2: A quota write (cfgWe high) while kernelActive is low loads cfgQuota into the quota of cluster cfgIdx and clears that cluster's counter at the next edge; a write while kernelActive is high changes neither the quota nor the counter.
- R3: An accepted instruction is granted to the lowest-index cluster that is available, in its group, has a nonzero quota and a counter below its quota; that counter rises by exactly one at the next clock edge.
- R4: instType 0 selects the arithmetic group (clusters 0 to 5, grant bits 5:0) and instType 1 selects the special-function group (clusters 6 and 7, grant bits 7:6); a grant never leaves the selected group.
- R5: A cluster whose quota is zero never receives a grant and counts as having met its quota.
- R6: When every cluster of the requesting group has its counter at or above its quota, the accepted instruction starts a new round: all counters of that group clear, the granted cluster's counter becomes 1, and the other group's counters are unchanged.
- R7: instReady is high only when kernelActive is high and some cluster of the requested group is eligible (taking a pending round restart into account); otherwise the request stalls and no counter changes.
- R8: grant is one-hot in the cycle of a handshake (instValid and instReady both high) and all zeros in every other cycle.
- R9: cntOut shows the current counter of cluster cntSel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kernelActive | input | 1 | High while a kernel runs; blocks quota writes, enables issue |
| cfgWe | input | 1 | Quota write strobe |
| cfgIdx | input | 3 | Cluster index of the quota write |
| cfgQuota | input | 16 | Quota value to write |
| instValid | input | 1 | Scheduler has an instruction ready |
| instType | input | 1 | 0 arithmetic, 1 special-function |
| instReady | output | 1 | Dispatcher can accept an instruction of instType |
| clusterAvail | input | 8 | Per-cluster availability flags |
| grant | output | 8 | One-hot target cluster for the accepted instruction |
| cntSel | input | 3 | Cluster whose counter is read back |
| cntOut | output | 16 | Issued count of cluster cntSel |

## Verification
The assertions assume that cntSel, instType and clusterAvail are stable for the sampled cycle and that a grant is only meaningful together with instValid, so the counter-step property only checks when cntSel is held over the edge. The stimulus drives every input once per cycle at the falling clock edge, keeps quotas small (0 to 5) so that round restarts occur often, holds availability mostly high with random holes, and mixes in quota writes while a kernel is running so that the ignored-write path is exercised against the behavioural model.

// File: rtl/qd_pkg.sv
package qd_pkg;
  localparam int SP_CLUSTERS  = 6;
  localparam int SFU_CLUSTERS = 2;
  localparam int CLUSTERS     = SP_CLUSTERS + SFU_CLUSTERS;
  localparam int IDX_W        = $clog2(CLUSTERS);
  localparam int QUOTA_W      = 16;

  typedef enum logic {
    INST_SP  = 1'b0,
    INST_SFU = 1'b1
  } instKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                cfgLoad;
    logic [CLUSTERS-1:0] incMask;
    logic [CLUSTERS-1:0] clrMask;
  } dpStrobe_t;
endpackage

// File: rtl/qd_first_pick.sv
module qd_first_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] reqVec,
  output logic [W-1:0] pickOh,
  output logic         anyReq
);
  // Isolate the lowest set bit
  assign pickOh = reqVec & (~reqVec + W'(1));
  assign anyReq = |reqVec;
endmodule

// File: rtl/qd_datapath.sv
module qd_datapath
  import qd_pkg::*;
#(
  parameter int CNT_W = QUOTA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic [CNT_W-1:0] cfgQuota,
  input  logic [IDX_W-1:0] cntSel,
  output logic [CLUSTERS-1:0] underQuota,
  output logic [CLUSTERS-1:0] quotaLive,
  output logic [CNT_W-1:0] cntOut
);
  logic [CNT_W-1:0] quotaReg [CLUSTERS];
  logic [CNT_W-1:0] issueCnt [CLUSTERS];

  for (genvar i = 0; i < CLUSTERS; i++) begin : g_cluster
    always_ff @(posedge clk) begin
      if (!rstN) begin
        quotaReg[i] <= '0;
        issueCnt[i] <= '0;
      end else if (strb.cfgLoad && cfgIdx == IDX_W'(i)) begin
        quotaReg[i] <= cfgQuota;
        issueCnt[i] <= '0;
      end else if (strb.clrMask[i]) begin
        issueCnt[i] <= strb.incMask[i] ? CNT_W'(1) : '0;
      end else if (strb.incMask[i]) begin
        issueCnt[i] <= issueCnt[i] + CNT_W'(1);
      end
    end

    assign underQuota[i] = issueCnt[i] < quotaReg[i];
    assign quotaLive[i]  = quotaReg[i] != '0;
  end

  assign cntOut = issueCnt[cntSel];
endmodule

// File: rtl/qd_control.sv
module qd_control
  import qd_pkg::*;
(
  input  logic                kernelActive,
  input  logic                cfgWe,
  input  logic                instValid,
  input  instKind_e           instKind,
  input  logic [CLUSTERS-1:0] clusterAvail,
  input  logic [CLUSTERS-1:0] underQuota,
  input  logic [CLUSTERS-1:0] quotaLive,
  output logic                instReady,
  output logic [CLUSTERS-1:0] grant,
  output dpStrobe_t           strb
);
  logic [CLUSTERS-1:0] groupMask;
  logic [CLUSTERS-1:0] eligible;
  logic [CLUSTERS-1:0] firstOh;
  logic                anyElig;
  logic                groupDone;
  logic                fire;

  for (genvar i = 0; i < CLUSTERS; i++) begin : g_group
    if (i < SP_CLUSTERS) begin : g_sp
      assign groupMask[i] = (instKind == INST_SP);
    end else begin : g_sfu
      assign groupMask[i] = (instKind == INST_SFU);
    end
  end

  // A zero quota never reads as under quota, so it counts as met
  assign groupDone = &(~groupMask | ~underQuota);
  assign eligible  = groupMask & clusterAvail & quotaLive &
                     (underQuota | {CLUSTERS{groupDone}});

  qd_first_pick #(.W(CLUSTERS)) u_pick (
    .reqVec (eligible),
    .pickOh (firstOh),
    .anyReq (anyElig)
  );

  assign instReady = kernelActive && anyElig;
  assign fire      = instValid && instReady;

  always_comb begin
    grant        = fire ? firstOh : '0;
    strb.cfgLoad = cfgWe && !kernelActive;
    strb.incMask = grant;
    strb.clrMask = (fire && groupDone) ? groupMask : '0;
  end
endmodule

// File: rtl/quota_dispatch.sv
module quota_dispatch
  import qd_pkg::*;
#(
  parameter int CNT_W = QUOTA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                kernelActive,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [CNT_W-1:0]    cfgQuota,
  input  logic                instValid,
  input  logic                instType,
  output logic                instReady,
  input  logic [CLUSTERS-1:0] clusterAvail,
  output logic [CLUSTERS-1:0] grant,
  input  logic [IDX_W-1:0]    cntSel,
  output logic [CNT_W-1:0]    cntOut
);
  dpStrobe_t           strb;
  logic [CLUSTERS-1:0] underQuota;
  logic [CLUSTERS-1:0] quotaLive;

  qd_control u_ctrl (
    .kernelActive (kernelActive),
    .cfgWe        (cfgWe),
    .instValid    (instValid),
    .instKind     (instKind_e'(instType)),
    .clusterAvail (clusterAvail),
    .underQuota   (underQuota),
    .quotaLive    (quotaLive),
    .instReady    (instReady),
    .grant        (grant),
    .strb         (strb)
  );

  qd_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgIdx     (cfgIdx),
    .cfgQuota   (cfgQuota),
    .cntSel     (cntSel),
    .underQuota (underQuota),
    .quotaLive  (quotaLive),
    .cntOut     (cntOut)
  );
endmodule

// File: rtl/qd_checker.sv
module qd_checker
  import qd_pkg::*;
#(
  parameter int CNT_W = QUOTA_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                kernelActive,
  input logic                instValid,
  input logic                instType,
  input logic                instReady,
  input logic [CLUSTERS-1:0] clusterAvail,
  input logic [CLUSTERS-1:0] grant,
  input logic [IDX_W-1:0]    cntSel,
  input logic [CNT_W-1:0]    cntOut
);
  localparam logic [CLUSTERS-1:0] SP_MASK = CLUSTERS'((1 << SP_CLUSTERS) - 1);

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R8
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && instReady) |-> grant == '0);

  // R8
  grant_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady) |-> $countones(grant) == 1);

  // R4
  grant_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instType ? (grant & SP_MASK) : (grant & ~SP_MASK)) == '0);

  // R3
  grant_avail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~clusterAvail) == '0);

  // R7
  idle_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !kernelActive |-> !instReady);

  // R3
  counter_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady && grant[cntSel]) |=>
      (!$stable(cntSel) || cntOut == $past(cntOut) + CNT_W'(1) || cntOut == CNT_W'(1)));
endmodule

bind quota_dispatch qd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .kernelActive (kernelActive),
  .instValid    (instValid),
  .instType     (instType),
  .instReady    (instReady),
  .clusterAvail (clusterAvail),
  .grant        (grant),
  .cntSel       (cntSel),
  .cntOut       (cntOut)
);

// File: tb/quota_dispatch_test.sv
`timescale 1ns/1ps
module quota_dispatch_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        kernelActive, cfgWe, instValid, instType;
  logic [2:0]  cfgIdx, cntSel;
  logic [15:0] cfgQuota, cntOut;
  logic [7:0]  clusterAvail, grant;
  logic        instReady;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int quota [8];
  int cnt   [8];

  always #5 clk = ~clk;

  quota_dispatch uut (
    .clk(clk), .rstN(rstN), .kernelActive(kernelActive), .cfgWe(cfgWe),
    .cfgIdx(cfgIdx), .cfgQuota(cfgQuota), .instValid(instValid),
    .instType(instType), .instReady(instReady), .clusterAvail(clusterAvail),
    .grant(grant), .cntSel(cntSel), .cntOut(cntOut)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at falling edge, compare against the model, advance the model
  task automatic cycle(bit ka, bit we, int idx, int qv, bit vld, bit typ,
                       logic [7:0] av, int sel);
    bit done;
    int first;
    int expGrant;
    @(negedge clk);
    kernelActive = ka; cfgWe = we; cfgIdx = 3'(idx); cfgQuota = 16'(qv);
    instValid = vld; instType = typ; clusterAvail = av; cntSel = 3'(sel);
    #1;
    done = 1;
    for (int i = 0; i < 8; i++)
      if (((i >= 6) == typ) && cnt[i] < quota[i]) done = 0;
    first = -1;
    if (ka)
      for (int i = 0; i < 8; i++)
        if (first < 0 && ((i >= 6) == typ) && av[i] && quota[i] != 0 &&
            (done || cnt[i] < quota[i])) first = i;
    expGrant = (vld && first >= 0) ? (1 << first) : 0;
    chk("R7 instReady", int'(instReady), int'(first >= 0));
    chk((done && vld && first >= 0) ? "R6 grant after round restart" : "R3 grant",
        int'(grant), expGrant);
    chk("R9 readback", int'(cntOut), cnt[sel]);
    chk("R8 grant ones", $countones(grant), (vld && first >= 0) ? 1 : 0);
    chk("R4 grant group", int'(typ ? grant[5:0] : {4'b0, grant[7:6]}), 0);
    for (int i = 0; i < 8; i++)
      if (quota[i] == 0) chk("R5 zero quota grant", int'(grant[i]), 0);
    if (we && !ka) begin
      quota[idx] = qv;
      cnt[idx] = 0;
    end
    if (vld && first >= 0) begin
      if (done)
        for (int i = 0; i < 8; i++) if ((i >= 6) == typ) cnt[i] = 0;
      cnt[first]++;
    end
  endtask

  initial begin
    int spExp [4];
    int sfuExp [5];
    int qInit [8];
    spExp  = '{1, 1, 4, 1};
    sfuExp = '{64, 128, 128, 128, 64};
    qInit  = '{2, 0, 1, 0, 0, 0, 1, 3};
    for (int i = 0; i < 8; i++) begin quota[i] = 0; cnt[i] = 0; end
    rstN = 1'b0; kernelActive = 0; cfgWe = 0; cfgIdx = 0; cfgQuota = 0;
    instValid = 1; instType = 0; clusterAvail = 8'hFF; cntSel = 0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); kernelActive = 1; cntSel = 3'(i); #1;
      chk("R1 reset counter", int'(cntOut), 0);
      chk("R1 reset grant", int'(grant), 0);
      chk("R1 reset ready", int'(instReady), 0);
    end
    @(negedge clk); rstN = 1'b1; kernelActive = 0;

    for (int i = 0; i < 8; i++) cycle(0, 1, i, qInit[i], 0, 0, 8'hFF, i);
    for (int k = 0; k < 4; k++) begin
      cycle(1, 0, 0, 0, 1, 0, 8'hFF, 0);
      chk(k == 3 ? "R6 arithmetic restart" : "R3 arithmetic order", int'(grant), spExp[k]);
    end
    for (int k = 0; k < 5; k++) begin
      cycle(1, 0, 0, 0, 1, 1, 8'hFF, 7);
      chk(k == 4 ? "R6 special restart" : "R4 special group", int'(grant), sfuExp[k]);
    end
    // Other group untouched by special-function restart
    cycle(1, 0, 0, 0, 0, 0, 8'hFF, 0);
    chk("R6 other group kept", int'(cntOut), 1);
    // Write during active kernel must be ignored
    cycle(1, 1, 0, 9, 0, 0, 8'hFF, 0);
    cycle(1, 0, 0, 0, 1, 0, 8'hFF, 0);
    cycle(1, 0, 0, 0, 1, 0, 8'hFF, 0);
    chk("R2 ignored write", int'(grant), 4);
    cycle(0, 1, 2, 2, 0, 0, 8'hFF, 2);
    cycle(0, 0, 0, 0, 0, 0, 8'hFF, 2);
    chk("R2 load clears counter", int'(cntOut), 0);
    cycle(1, 0, 0, 0, 1, 0, 8'b0000_0010, 0);
    chk("R7 stall on zero quota only", int'(instReady), 0);
    chk("R5 zero quota cluster", int'(grant), 0);
    cycle(0, 0, 0, 0, 1, 0, 8'hFF, 0);
    chk("R7 stall when idle", int'(instReady), 0);

    for (int blk = 0; blk < 12; blk++) begin
      for (int i = 0; i < 8; i++)
        cycle(0, 1, i, (blk % 4 == 3) ? 0 : int'($urandom_range(0, 5)), 0, 0, 8'hFF, i);
      for (int c = 0; c < 250; c++)
        cycle(1, ($urandom_range(0, 15) == 0), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 5)), $urandom_range(0, 3) != 0,
              1'($urandom_range(0, 1)), 8'($urandom | $urandom),
              int'($urandom_range(0, 7)));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule